// File: doc/BRIEF.md
# Operand Bypass and Hazard Control Unit

This unit steers the operand bypass paths and the interlocks of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). For each source operand of the instruction in execute it decides whether the value comes from the register file, from the result held after execute, or from the result held after the memory stage. A producer three slots ahead needs no bypass, because the register file writes early in the cycle and reads late. When a load sits in execute and the instruction behind it in decode needs the loaded register, the unit freezes the program counter and the fetch/decode register for one cycle and turns the instruction entering execute into a bubble.

Branches are handled in one of two modes chosen by a parameter. In the predict-not-taken mode, sequential instructions keep flowing. When a branch resolves taken at the memory stage, the unit raises a flush that kills the three younger instructions, so that none of them writes memory or registers. In the always-stall mode, no flush is ever raised. Instead, the unit holds fetch and feeds bubbles for a fixed number of cycles each time a branch leaves decode. The unit has no datapath of its own. Only the branch-hold counter in the always-stall mode holds state.

Top module: `hz_unit`

## Requirements
- R1: For each execute operand, the select is 2'b10 (take the result after execute) when the execute/memory register has its write flag set, a nonzero destination, and a destination equal to that operand's register number.
- R2: The select is 2'b01 (take the result after memory) when the memory/writeback register has its write flag set, a nonzero destination, and a destination equal to the operand, and R1 does not apply. A match found only further back gives 2'b00.
- R3: When both later stages match the same operand, the nearer one (2'b10) wins.
- R4: Register 0, or a producer whose write flag is clear, never causes a bypass. With no match the select is 2'b00 (register file). The value 2'b11 never appears.
- R5: stall and bubble are 1 in the same cycle whenever the execute-stage instruction has both its memory-read and write flags set, its destination is nonzero, and its destination equals either decode-stage source, and no flush is raised in that cycle.
- R6: stall is 0 when the execute-stage instruction is not a load, even if its destination matches a decode source. stall is also 0 for a load whose destination is register 0.
- R7: In predict-not-taken mode (BR_MODE 0), flush and bubble are 1 exactly in the cycles where a resolving branch is reported taken.
- R8: When flush is 1, stall is 0.
- R9: In always-stall mode (BR_MODE 1), flush is never 1. fetch_hold is 1 for BR_PENALTY consecutive cycles starting in the cycle a branch is in decode and not stalled.
- R10: In predict-not-taken mode, fetch_hold is never 1.
- R11: During and right after reset, with idle inputs, every output is 0 and the always-stall counter is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_srcs | input | NUM_SRC*REG_AW | Decode-stage source register numbers, operand 0 in the low bits |
| id_is_branch | input | 1 | Decode stage holds a branch |
| ex_srcs | input | NUM_SRC*REG_AW | Execute-stage source register numbers, operand 0 in the low bits |
| idex_rd | input | REG_AW | Destination register in the decode/execute register |
| idex_regwr | input | 1 | Register write flag in the decode/execute register |
| idex_memrd | input | 1 | Memory read flag in the decode/execute register |
| exmem_rd | input | REG_AW | Destination register in the execute/memory register |
| exmem_regwr | input | 1 | Register write flag in the execute/memory register |
| memwb_rd | input | REG_AW | Destination register in the memory/writeback register |
| memwb_regwr | input | 1 | Register write flag in the memory/writeback register |
| br_resolve | input | 1 | A branch resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| fwd_sel | output | NUM_SRC*2 | Bypass select per execute operand, operand 0 in the low bits |
| stall | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble | output | 1 | Zero the control bits entering execute |
| flush | output | 1 | Kill the three younger instructions and block their writes |
| fetch_hold | output | 1 | Always-stall mode: hold fetch and feed a bubble |

## Verification
The assertions assume that the pipeline around the unit behaves consistently. While fetch_hold runs, no new branch reaches decode, so each hold run is a whole multiple of BR_PENALTY. br_taken matters only when br_resolve is set. The scripted sequences honour this: they raise id_is_branch only once the previous hold has ended. The random sweep draws register numbers from a narrow range so that matches are frequent, and its reference model follows whatever branch pattern is driven, so that phase makes no assumption about branch spacing.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_RF    = 2'b00,
      FWD_MEMWB = 2'b01,
      FWD_EXMEM = 2'b10
   } fwd_sel_e;

   localparam int unsigned FWD_W = 2;

   localparam int BR_PREDICT_NT   = 0;
   localparam int BR_ALWAYS_STALL = 1;
endpackage

// File: rtl/hz_dst_match.sv
module hz_dst_match #(
   parameter int REG_AW    = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] dst,
   input  logic              wr,
   input  logic [REG_AW-1:0] src,
   output logic              hit
);
   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign hit = wr && (dst != '0) && (dst == src);
      end else begin : g_zero_soft
         assign hit = wr && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
   import hz_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] exmem_rd,
   input  logic              exmem_regwr,
   input  logic [REG_AW-1:0] memwb_rd,
   input  logic              memwb_regwr,
   output logic [FWD_W-1:0]  sel
);
   logic near_hit;
   logic far_hit;

   hz_dst_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_near (
      .dst(exmem_rd), .wr(exmem_regwr), .src(src), .hit(near_hit)
   );
   hz_dst_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_far (
      .dst(memwb_rd), .wr(memwb_regwr), .src(src), .hit(far_hit)
   );

   always_comb begin
      fwd_sel_e choice;
      if (near_hit)      choice = FWD_EXMEM;
      else if (far_hit)  choice = FWD_MEMWB;
      else               choice = FWD_RF;
      sel = choice;
   end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_AW    = 5,
   parameter int NUM_SRC   = 2,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0]         idex_rd,
   input  logic                      idex_regwr,
   input  logic                      idex_memrd,
   input  logic [NUM_SRC*REG_AW-1:0] id_srcs,
   output logic                      hit
);
   logic [NUM_SRC-1:0] per_src;
   logic               is_load;

   assign is_load = idex_memrd && idex_regwr;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      hz_dst_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_m (
         .dst(idex_rd), .wr(is_load),
         .src(id_srcs[i*REG_AW +: REG_AW]), .hit(per_src[i])
      );
   end

   assign hit = |per_src;
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl
   import hz_pkg::*;
#(
   parameter int BR_MODE    = BR_PREDICT_NT,
   parameter int BR_PENALTY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic id_is_branch,
   input  logic load_use,
   input  logic br_resolve,
   input  logic br_taken,
   output logic flush,
   output logic fetch_hold
);
   localparam bit IS_STALL = (BR_MODE == BR_ALWAYS_STALL);
   localparam int CW       = (BR_PENALTY < 2) ? 1 : $clog2(BR_PENALTY);
   localparam logic [CW-1:0] RELOAD = CW'(BR_PENALTY - 1);

   logic [CW-1:0] cnt;
   logic          busy;
   logic          start;

   assign busy  = (cnt != '0);
   assign start = IS_STALL && id_is_branch && !load_use && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= RELOAD;
      else if (busy)   cnt <= cnt - 1'b1;
   end

   assign flush      = !IS_STALL && br_resolve && br_taken;
   assign fetch_hold = IS_STALL && ((id_is_branch && !load_use) || busy);
endmodule

// File: rtl/hz_unit.sv
module hz_unit
   import hz_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter int NUM_SRC       = 2,
   parameter int BR_MODE       = BR_PREDICT_NT,
   parameter int BR_PENALTY    = 3,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC*REG_AW-1:0] id_srcs,
   input  logic                      id_is_branch,
   input  logic [NUM_SRC*REG_AW-1:0] ex_srcs,
   input  logic [REG_AW-1:0]         idex_rd,
   input  logic                      idex_regwr,
   input  logic                      idex_memrd,
   input  logic [REG_AW-1:0]         exmem_rd,
   input  logic                      exmem_regwr,
   input  logic [REG_AW-1:0]         memwb_rd,
   input  logic                      memwb_regwr,
   input  logic                      br_resolve,
   input  logic                      br_taken,
   output logic [NUM_SRC*FWD_W-1:0]  fwd_sel,
   output logic                      stall,
   output logic                      bubble,
   output logic                      flush,
   output logic                      fetch_hold
);
   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hz_unit: REG_AW out of range");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("hz_unit: NUM_SRC out of range");
      end
      if (BR_PENALTY < 1 || BR_PENALTY > 64) begin : g_bad_pen
         $error("hz_unit: BR_PENALTY out of range");
      end
      if (BR_MODE != BR_PREDICT_NT && BR_MODE != BR_ALWAYS_STALL) begin : g_bad_mode
         $error("hz_unit: unknown BR_MODE");
      end
   endgenerate

   logic load_use;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
      hz_src_fwd #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_REG_HARD)) u_fwd (
         .src         (ex_srcs[i*REG_AW +: REG_AW]),
         .exmem_rd    (exmem_rd),
         .exmem_regwr (exmem_regwr),
         .memwb_rd    (memwb_rd),
         .memwb_regwr (memwb_regwr),
         .sel         (fwd_sel[i*FWD_W +: FWD_W])
      );
   end

   hz_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .ZERO_HARD(ZERO_REG_HARD)) u_lu (
      .idex_rd    (idex_rd),
      .idex_regwr (idex_regwr),
      .idex_memrd (idex_memrd),
      .id_srcs    (id_srcs),
      .hit        (load_use)
   );

   hz_branch_ctl #(.BR_MODE(BR_MODE), .BR_PENALTY(BR_PENALTY)) u_br (
      .clk          (clk),
      .rst_n        (rst_n),
      .id_is_branch (id_is_branch),
      .load_use     (load_use),
      .br_resolve   (br_resolve),
      .br_taken     (br_taken),
      .flush        (flush),
      .fetch_hold   (fetch_hold)
   );

   assign stall  = load_use && !flush;
   assign bubble = stall || flush;
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk
   import hz_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter int NUM_SRC       = 2,
   parameter int BR_MODE       = BR_PREDICT_NT,
   parameter int BR_PENALTY    = 3,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_SRC*REG_AW-1:0] id_srcs,
   input logic                      id_is_branch,
   input logic [NUM_SRC*REG_AW-1:0] ex_srcs,
   input logic [REG_AW-1:0]         idex_rd,
   input logic                      idex_regwr,
   input logic                      idex_memrd,
   input logic [REG_AW-1:0]         exmem_rd,
   input logic                      exmem_regwr,
   input logic [REG_AW-1:0]         memwb_rd,
   input logic                      memwb_regwr,
   input logic                      br_resolve,
   input logic                      br_taken,
   input logic [NUM_SRC*FWD_W-1:0]  fwd_sel,
   input logic                      stall,
   input logic                      bubble,
   input logic                      flush,
   input logic                      fetch_hold
);
   localparam bit IS_STALL = (BR_MODE == BR_ALWAYS_STALL);

   logic [NUM_SRC-1:0] id_eq;
   logic [15:0]        run;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
      logic [REG_AW-1:0] s;
      logic [1:0]        q;
      assign s = ex_srcs[i*REG_AW +: REG_AW];
      assign q = fwd_sel[i*FWD_W +: FWD_W];
      assign id_eq[i] = (idex_rd == id_srcs[i*REG_AW +: REG_AW]);

      AST_FWD_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (exmem_regwr && exmem_rd != '0 && exmem_rd == s) |-> q == 2'b10); // R1
      AST_FWD_FAR: assert property (@(posedge clk) disable iff (!rst_n)
         (q == 2'b01) |-> (memwb_regwr && memwb_rd == s &&
                           !(exmem_regwr && exmem_rd != '0 && exmem_rd == s))); // R2
      AST_FWD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         q != 2'b11); // R4
      if (ZERO_REG_HARD) begin : g_z
         AST_FWD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (s == '0) |-> q == 2'b00); // R4
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          run <= '0;
      else if (fetch_hold) run <= run + 1'b1;
      else                 run <= '0;
   end

   AST_STALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (idex_memrd && idex_regwr && idex_rd != '0 && (|id_eq))); // R6
   AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> bubble); // R5
   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (br_resolve && br_taken && bubble)); // R7
   AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !stall); // R8
   AST_HOLD_START: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_STALL && id_is_branch && !stall) |-> fetch_hold); // R9
   AST_STALLMODE_NOFLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      IS_STALL |-> !flush); // R9
   AST_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_hold && run != '0) |-> (int'(run) % BR_PENALTY) == 0); // R9
   AST_PNT_NOHOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !IS_STALL |-> !fetch_hold); // R10
endmodule

bind hz_unit hz_unit_chk #(
   .REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .BR_MODE(BR_MODE),
   .BR_PENALTY(BR_PENALTY), .ZERO_REG_HARD(ZERO_REG_HARD)
) u_chk (.*);

// File: tb/tb_hz_unit.sv
`timescale 1ns/1ps
module tb_hz_unit;
   localparam int AW  = 5;
   localparam int NS  = 2;
   localparam int PEN = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS*AW-1:0] id_srcs = '0, ex_srcs = '0;
   logic id_is_branch = 0;
   logic [AW-1:0] idex_rd = '0, exmem_rd = '0, memwb_rd = '0;
   logic idex_regwr = 0, idex_memrd = 0, exmem_regwr = 0, memwb_regwr = 0;
   logic br_resolve = 0, br_taken = 0;

   logic [NS*2-1:0] p_fwd, s_fwd;
   logic p_stall, p_bubble, p_flush, p_hold;
   logic s_stall, s_bubble, s_flush, s_hold;

   int n_tests = 0;
   int n_fail  = 0;
   int cnt_m   = 0;
   string cur_req = "R11";
   bit done = 0;

   always #2.5 clk = ~clk;

   hz_unit #(.REG_AW(AW), .NUM_SRC(NS), .BR_MODE(0), .BR_PENALTY(PEN)) dut (
      .clk, .rst_n, .id_srcs, .id_is_branch, .ex_srcs, .idex_rd, .idex_regwr,
      .idex_memrd, .exmem_rd, .exmem_regwr, .memwb_rd, .memwb_regwr,
      .br_resolve, .br_taken, .fwd_sel(p_fwd), .stall(p_stall),
      .bubble(p_bubble), .flush(p_flush), .fetch_hold(p_hold));

   hz_unit #(.REG_AW(AW), .NUM_SRC(NS), .BR_MODE(1), .BR_PENALTY(PEN)) dut_as (
      .clk, .rst_n, .id_srcs, .id_is_branch, .ex_srcs, .idex_rd, .idex_regwr,
      .idex_memrd, .exmem_rd, .exmem_regwr, .memwb_rd, .memwb_regwr,
      .br_resolve, .br_taken, .fwd_sel(s_fwd), .stall(s_stall),
      .bubble(s_bubble), .flush(s_flush), .fetch_hold(s_hold));

   // reference model
   function automatic int exp_fwd(input logic [AW-1:0] s);
      if (exmem_regwr && exmem_rd != 0 && exmem_rd == s) return 2;
      if (memwb_regwr && memwb_rd != 0 && memwb_rd == s) return 1;
      return 0;
   endfunction

   function automatic bit exp_lu();
      if (!(idex_memrd && idex_regwr) || idex_rd == 0) return 0;
      for (int i = 0; i < NS; i++)
         if (idex_rd == id_srcs[i*AW +: AW]) return 1;
      return 0;
   endfunction

   task automatic chk(input string what, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         bit lu, fl, sh;
         lu = exp_lu();
         fl = br_resolve && br_taken;
         sh = (id_is_branch && !lu) || (cnt_m != 0);
         for (int i = 0; i < NS; i++) begin
            chk("fwd_sel pnt", int'(p_fwd[i*2 +: 2]), exp_fwd(ex_srcs[i*AW +: AW]));
            chk("fwd_sel as",  int'(s_fwd[i*2 +: 2]), exp_fwd(ex_srcs[i*AW +: AW]));
         end
         chk("stall pnt (R5 R8)", p_stall, lu && !fl);
         chk("bubble pnt (R5 R7)", p_bubble, (lu && !fl) || fl);
         chk("flush pnt (R7)", p_flush, fl);
         chk("hold pnt (R10)", p_hold, 0);
         chk("stall as (R5)", s_stall, lu);
         chk("bubble as (R5)", s_bubble, lu);
         chk("flush as (R9)", s_flush, 0);
         chk("hold as (R9)", s_hold, sh);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) cnt_m = 0;
      else if (id_is_branch && !exp_lu() && cnt_m == 0) cnt_m = PEN - 1;
      else if (cnt_m != 0) cnt_m = cnt_m - 1;
   end

   task automatic nxt();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      id_srcs = '0; ex_srcs = '0; id_is_branch = 0;
      idex_rd = '0; exmem_rd = '0; memwb_rd = '0;
      idex_regwr = 0; idex_memrd = 0; exmem_regwr = 0; memwb_regwr = 0;
      br_resolve = 0; br_taken = 0;
   endtask

   task automatic ex_ops(input int a, input int b);
      ex_srcs = {AW'(b), AW'(a)};
   endtask

   task automatic id_ops(input int a, input int b);
      id_srcs = {AW'(b), AW'(a)};
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle();
      cur_req = "R11";
      repeat (3) nxt();
      rst_n = 1;
      nxt();
      // R1: producer one ahead
      cur_req = "R1"; ex_ops(5, 6); exmem_rd = 5; exmem_regwr = 1; nxt();
      ex_ops(3, 12); exmem_rd = 12; nxt();
      // R2: producer two ahead, and distance three gives register file
      idle(); cur_req = "R2"; ex_ops(1, 7); memwb_rd = 7; memwb_regwr = 1; nxt();
      ex_ops(7, 7); nxt();
      idle(); ex_ops(9, 10); nxt();
      // R3: both stages match
      cur_req = "R3"; ex_ops(9, 9); exmem_rd = 9; exmem_regwr = 1;
      memwb_rd = 9; memwb_regwr = 1; nxt();
      ex_ops(9, 4); memwb_rd = 4; nxt();
      // R4: register 0 and cleared write flag
      idle(); cur_req = "R4"; ex_ops(0, 0); exmem_regwr = 1; memwb_regwr = 1; nxt();
      ex_ops(8, 8); exmem_rd = 8; memwb_rd = 8; exmem_regwr = 0; memwb_regwr = 0; nxt();
      // R5: load-use
      idle(); cur_req = "R5"; id_ops(2, 4); idex_rd = 4; idex_regwr = 1; idex_memrd = 1; nxt();
      id_ops(4, 0); nxt();
      // R6: non-load match, and load to register 0
      idle(); cur_req = "R6"; id_ops(4, 4); idex_rd = 4; idex_regwr = 1; nxt();
      id_ops(0, 0); idex_rd = 0; idex_memrd = 1; nxt();
      // R7: taken and not-taken resolution
      idle(); cur_req = "R7"; br_resolve = 1; br_taken = 1; nxt();
      br_taken = 0; nxt();
      br_resolve = 0; br_taken = 1; nxt();
      // R8: flush over load-use
      idle(); cur_req = "R8"; id_ops(6, 1); idex_rd = 6; idex_regwr = 1; idex_memrd = 1;
      br_resolve = 1; br_taken = 1; nxt();
      // R9/R10: branch in decode, then bubbles
      idle(); cur_req = "R9"; id_is_branch = 1; nxt();
      id_is_branch = 0; repeat (PEN + 1) nxt();
      // branch blocked by load-use does not start the hold
      id_is_branch = 1; id_ops(3, 0); idex_rd = 3; idex_regwr = 1; idex_memrd = 1; nxt();
      idle(); id_is_branch = 1; nxt();
      id_is_branch = 0; repeat (PEN + 1) nxt();
      cur_req = "R10"; nxt();
      // random sweep with a narrow register range
      cur_req = "R1 R2 R3 R4 R5 R6 R7 R8 R9";
      for (int k = 0; k < 400; k++) begin
         id_ops($urandom_range(0, 3), $urandom_range(0, 3));
         ex_ops($urandom_range(0, 3), $urandom_range(0, 3));
         idex_rd = AW'($urandom_range(0, 3)); exmem_rd = AW'($urandom_range(0, 3));
         memwb_rd = AW'($urandom_range(0, 3));
         idex_regwr = 1'($urandom); idex_memrd = 1'($urandom);
         exmem_regwr = 1'($urandom); memwb_regwr = 1'($urandom);
         br_resolve = ($urandom_range(0, 3) == 0); br_taken = 1'($urandom);
         id_is_branch = (cnt_m == 0) && ($urandom_range(0, 3) == 0);
         nxt();
      end
      // R11: reset again clears the hold counter
      idle(); cur_req = "R11"; id_is_branch = 1; nxt();
      idle(); rst_n = 0; nxt();
      rst_n = 1; nxt();
      nxt();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule